// File: doc/BRIEF.md
# Three-Wire Serial Configuration Port

This block is the slave side of a three-wire configuration link for a three-color imaging front end. An external controller drives a serial clock, a frame strobe and a data line. The data line is split here into an input, an output and an output enable, and the pad ring joins them into one bidirectional pin. Each frame is 16 bits long and is sent most significant bit first. The frame holds a direction flag, a register address, a short ignored gap and a 9-bit payload. Write frames update one of eight internal registers. Read frames return a register's contents on the same line during the payload part of the frame.

The serial clock, the strobe and the data line are brought into the system clock domain through synchronizers, and their edges are detected there. The serial clock must therefore run several times slower than the system clock. The register contents are decoded into control outputs: number of channels, sampling mode, power-down, color order, single-channel color select, three gain codes and three offset codes in sign-magnitude form.

Top module: `cfg_serial_port`

## Requirements
- R1: A frame is sent MSB first and carries, in order: the direction bit (1 = read, 0 = write), address bits 2..0, three ignored bits, and data bits 8..0. Input bits are taken on rising serial clock edges.
- R2: A write takes effect only when the strobe falls after exactly 16 rising serial clock edges. Frames of any other length leave every register unchanged.
- R3: After reset, the decoded outputs are: three_channel=1, cds_mode=1, power_down=0, order_rgb=1, single_sel=3'b100, all gains 0 and all offsets 0.
- R4: Register 0 holds three_channel in bit 4, cds_mode in bit 3 and power_down in bit 2. Its other bits read back as zero.
- R5: Register 1 holds order_rgb in bit 7 and the single-channel selects in bits 6 (red), 5 (green) and 4 (blue). These appear on single_sel[2:0] as {red, green, blue}. Its other bits read back as zero.
- R6: Registers 2, 3 and 4 (red, green, blue) hold a 6-bit straight-binary gain in bits 5..0, output on gain[5:0], gain[11:6] and gain[17:12]. Bits 8..6 read back as zero.
- R7: Registers 5, 6 and 7 (red, green, blue) hold a 9-bit sign-magnitude offset, with bit 8 as the sign. All nine bits are kept and output unchanged on offset[8:0], offset[17:9] and offset[26:18].
- R8: A read frame returns the addressed register's stored value on sdata_out, MSB first, one bit per payload position. Each bit is updated after a falling serial clock edge. A read changes no register.
- R9: sdata_oe goes high only after the falling edge that follows the 7th rising edge of a read frame. It falls after the 16th falling edge or when the strobe falls. It stays low during write frames and between frames.
- R10: The three address bits select one of eight registers: 0 configuration, 1 multiplexer, 2-4 gains, 5-7 offsets. Every address can be read back independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock from the controller, idle low |
| ser_load | input | 1 | Frame strobe, high for the length of a frame |
| sdata_in | input | 1 | Serial data from the pad |
| sdata_out | output | 1 | Serial read data toward the pad |
| sdata_oe | output | 1 | Pad output enable for sdata_out |
| three_channel | output | 1 | 1 = three-channel operation |
| cds_mode | output | 1 | 1 = correlated double sampling, 0 = sample-and-hold |
| power_down | output | 1 | 1 = powered down |
| order_rgb | output | 1 | 1 = red-green-blue order, 0 = blue-green-red |
| single_sel | output | 3 | Single-channel select {red, green, blue} |
| gain | output | 18 | Gain codes, red in the low slice |
| offset | output | 27 | Sign-magnitude offset codes, red in the low slice |

## Verification
The bench sends frames that are one bit too short and one bit too long to a register that already holds a known value. A design that counts edges wrongly, or commits on the 16th edge instead of at the strobe fall, would overwrite that value. Reads are checked at every address after writes that set all nine bits. This shows whether unused bits are masked, and whether a design that drove the MSB one bit late or from the wrong register returns shifted or foreign data. The output enable is sampled at every bit slot of both read and write frames, so driving during the header or during writes is caught. Negative zero and the full-scale negative offset are written to confirm that the sign bit is kept as written and not reinterpreted.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

   localparam int unsigned NUM_COLORS    = 3;
   localparam int unsigned GAIN_BASE     = 2;
   localparam int unsigned OFFSET_BASE   = 5;

   localparam int unsigned CFG_THREE_BIT = 4;
   localparam int unsigned CFG_CDS_BIT   = 3;
   localparam int unsigned CFG_PD_BIT    = 2;
   localparam int unsigned MUX_ORDER_BIT = 7;
   localparam int unsigned MUX_RED_BIT   = 6;

   typedef enum logic [2:0] {
      REG_CONFIG = 3'd0,
      REG_MUX    = 3'd1,
      REG_GAIN_R = 3'd2,
      REG_GAIN_G = 3'd3,
      REG_GAIN_B = 3'd4,
      REG_OFS_R  = 3'd5,
      REG_OFS_G  = 3'd6,
      REG_OFS_B  = 3'd7
   } reg_sel_e;

   // Writable bits of each register; everything else stores and reads zero.
   function automatic logic [8:0] reg_mask(input int unsigned idx, input int unsigned gain_w);
      logic [8:0] m;
      m = '0;
      if (idx == 0) begin
         m[CFG_THREE_BIT] = 1'b1;
         m[CFG_CDS_BIT]   = 1'b1;
         m[CFG_PD_BIT]    = 1'b1;
      end else if (idx == 1) begin
         m[MUX_ORDER_BIT] = 1'b1;
         m[MUX_RED_BIT]   = 1'b1;
         m[MUX_RED_BIT-1] = 1'b1;
         m[MUX_RED_BIT-2] = 1'b1;
      end else if (idx < OFFSET_BASE) begin
         for (int b = 0; b < 9; b++) m[b] = (b < int'(gain_w));
      end else begin
         m = '1;
      end
      return m;
   endfunction

   function automatic logic [8:0] reg_default(input int unsigned idx);
      logic [8:0] v;
      v = '0;
      if (idx == 0) begin
         v[CFG_THREE_BIT] = 1'b1;
         v[CFG_CDS_BIT]   = 1'b1;
      end else if (idx == 1) begin
         v[MUX_ORDER_BIT] = 1'b1;
         v[MUX_RED_BIT]   = 1'b1;
      end
      return v;
   endfunction

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
   parameter int unsigned WIDTH  = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   if (STAGES < 2) begin : g_bad_stages
      $error("cfg_sync: STAGES must be at least 2");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[STAGES-2:0], async_in[b]};
      end
      assign sync_out[b] = chain[STAGES-1];
   end

endmodule

// File: rtl/cfg_frame_rx.sv
module cfg_frame_rx #(
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned PAD_W  = 3,
   parameter int unsigned DATA_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck,
   input  logic              ld,
   input  logic              din,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] rd_data,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              dout,
   output logic              doe
);

   localparam int unsigned HDR_LEN   = 1 + ADDR_W + PAD_W;
   localparam int unsigned FRAME_LEN = HDR_LEN + DATA_W;
   localparam int unsigned CNT_W     = $clog2(FRAME_LEN + 2);
   localparam logic [CNT_W-1:0] C_HDR   = CNT_W'(HDR_LEN);
   localparam logic [CNT_W-1:0] C_FRAME = CNT_W'(FRAME_LEN);
   localparam logic [CNT_W-1:0] C_SAT   = CNT_W'(FRAME_LEN + 1);

   logic                 sck_q, ld_q;
   logic                 sck_rise, sck_fall, ld_rise, ld_fall;
   logic [FRAME_LEN-1:0] shift_q;
   logic [CNT_W-1:0]     cnt_q;
   logic [DATA_W-1:0]    rd_sh_q;

   assign sck_rise = sck & ~sck_q;
   assign sck_fall = ~sck & sck_q;
   assign ld_rise  = ld & ~ld_q;
   assign ld_fall  = ~ld & ld_q;

   assign rd_addr = shift_q[HDR_LEN-2 -: ADDR_W];
   assign wr_addr = shift_q[FRAME_LEN-2 -: ADDR_W];
   assign wr_data = shift_q[DATA_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q   <= 1'b0;
         ld_q    <= 1'b0;
         shift_q <= '0;
         cnt_q   <= '0;
         rd_sh_q <= '0;
         wr_en   <= 1'b0;
         dout    <= 1'b0;
         doe     <= 1'b0;
      end else begin
         sck_q <= sck;
         ld_q  <= ld;
         wr_en <= 1'b0;
         if (ld_rise) begin
            cnt_q <= '0;
            doe   <= 1'b0;
         end else if (ld) begin
            if (sck_rise) begin
               if (cnt_q < C_FRAME) shift_q <= {shift_q[FRAME_LEN-2:0], din};
               if (cnt_q != C_SAT)  cnt_q   <= cnt_q + 1'b1;
            end
            if (sck_fall) begin
               if (cnt_q == C_HDR && shift_q[HDR_LEN-1]) begin
                  doe     <= 1'b1;
                  dout    <= rd_data[DATA_W-1];
                  rd_sh_q <= {rd_data[DATA_W-2:0], 1'b0};
               end else if (doe && cnt_q < C_FRAME) begin
                  dout    <= rd_sh_q[DATA_W-1];
                  rd_sh_q <= {rd_sh_q[DATA_W-2:0], 1'b0};
               end else begin
                  doe <= 1'b0;
               end
            end
         end
         if (ld_fall) begin
            doe <= 1'b0;
            if (cnt_q == C_FRAME && !shift_q[FRAME_LEN-1]) wr_en <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
   import cfg_port_pkg::*;
#(
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned DATA_W = 9,
   parameter int unsigned GAIN_W = 6
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [ADDR_W-1:0]              wr_addr,
   input  logic [DATA_W-1:0]              wr_data,
   input  logic [ADDR_W-1:0]              rd_addr,
   output logic [DATA_W-1:0]              rd_data,
   output logic                           three_channel,
   output logic                           cds_mode,
   output logic                           power_down,
   output logic                           order_rgb,
   output logic [2:0]                     single_sel,
   output logic [NUM_COLORS*GAIN_W-1:0]   gain,
   output logic [NUM_COLORS*DATA_W-1:0]   offset
);

   localparam int unsigned NREG = 1 << ADDR_W;

   logic [DATA_W-1:0] regs [NREG];

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      localparam logic [DATA_W-1:0] MASK = DATA_W'(reg_mask(r, GAIN_W));
      localparam logic [DATA_W-1:0] INIT = DATA_W'(reg_default(r));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            regs[r] <= INIT;
         else if (wr_en && wr_addr == ADDR_W'(r))
            regs[r] <= wr_data & MASK;
      end
   end

   assign rd_data = regs[rd_addr];

   assign three_channel = regs[REG_CONFIG][CFG_THREE_BIT];
   assign cds_mode      = regs[REG_CONFIG][CFG_CDS_BIT];
   assign power_down    = regs[REG_CONFIG][CFG_PD_BIT];
   assign order_rgb     = regs[REG_MUX][MUX_ORDER_BIT];
   assign single_sel    = regs[REG_MUX][MUX_RED_BIT -: 3];

   for (genvar c = 0; c < NUM_COLORS; c++) begin : g_color
      assign gain[c*GAIN_W +: GAIN_W]   = regs[GAIN_BASE + c][GAIN_W-1:0];
      assign offset[c*DATA_W +: DATA_W] = regs[OFFSET_BASE + c];
   end

endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
   import cfg_port_pkg::*;
#(
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned PAD_W       = 3,
   parameter int unsigned DATA_W      = 9,
   parameter int unsigned GAIN_W      = 6,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         ser_clk,
   input  logic                         ser_load,
   input  logic                         sdata_in,
   output logic                         sdata_out,
   output logic                         sdata_oe,
   output logic                         three_channel,
   output logic                         cds_mode,
   output logic                         power_down,
   output logic                         order_rgb,
   output logic [2:0]                   single_sel,
   output logic [NUM_COLORS*GAIN_W-1:0] gain,
   output logic [NUM_COLORS*DATA_W-1:0] offset
);

   if (DATA_W != 9) begin : g_bad_data
      $error("cfg_serial_port: field positions assume a 9-bit payload");
   end
   if (ADDR_W != 3) begin : g_bad_addr
      $error("cfg_serial_port: register map needs exactly 3 address bits");
   end
   if (GAIN_W < 1 || GAIN_W > DATA_W) begin : g_bad_gain
      $error("cfg_serial_port: GAIN_W out of range");
   end

   logic              sck_s, ld_s, din_s;
   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr, rd_addr;
   logic [DATA_W-1:0] wr_data, rd_data;

   cfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in ({sdata_in, ser_load, ser_clk}),
      .sync_out ({din_s, ld_s, sck_s})
   );

   cfg_frame_rx #(.ADDR_W(ADDR_W), .PAD_W(PAD_W), .DATA_W(DATA_W)) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .sck     (sck_s),
      .ld      (ld_s),
      .din     (din_s),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .dout    (sdata_out),
      .doe     (sdata_oe)
   );

   cfg_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_regs (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_en         (wr_en),
      .wr_addr       (wr_addr),
      .wr_data       (wr_data),
      .rd_addr       (rd_addr),
      .rd_data       (rd_data),
      .three_channel (three_channel),
      .cds_mode      (cds_mode),
      .power_down    (power_down),
      .order_rgb     (order_rgb),
      .single_sel    (single_sel),
      .gain          (gain),
      .offset        (offset)
   );

endmodule

// File: rtl/cfg_serial_port_chk.sv
module cfg_serial_port_chk #(
   parameter int unsigned GW = 18,
   parameter int unsigned OW = 27
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ld_s,
   input logic          sck_s,
   input logic          doe,
   input logic          wr_en,
   input logic [6:0]    ctrl,
   input logic [GW-1:0] gain,
   input logic [OW-1:0] offset
);

   // R9: enable is dropped once the synchronized strobe has fallen
   a_r9_oe_off_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ld_s) |=> !doe);

   // R9: enable only turns on right after a falling serial clock edge
   a_r9_oe_on_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(doe) |-> ($past(sck_s, 2) && !$past(sck_s, 1)));

   // R2: commits happen only outside an active frame
   a_r2_write_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !ld_s);

   // R8: decoded settings move only after a commit pulse
   a_r8_state_held: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_en) |-> $stable({ctrl, gain, offset}));

   // R9: no drive while no frame is in progress
   a_r9_oe_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_s && !$past(ld_s)) |-> !doe);

endmodule

bind cfg_serial_port cfg_serial_port_chk #(
   .GW(cfg_port_pkg::NUM_COLORS * GAIN_W),
   .OW(cfg_port_pkg::NUM_COLORS * DATA_W)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .ld_s   (ld_s),
   .sck_s  (sck_s),
   .doe    (sdata_oe),
   .wr_en  (wr_en),
   .ctrl   ({three_channel, cds_mode, power_down, order_rgb, single_sel}),
   .gain   (gain),
   .offset (offset)
);

// File: tb/cfg_serial_port_test.sv
module cfg_serial_port_test;

   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ser_clk = 1'b0;
   logic        ser_load = 1'b0;
   logic        sdata_in = 1'b0;
   logic        sdata_out, sdata_oe;
   logic        three_channel, cds_mode, power_down, order_rgb;
   logic [2:0]  single_sel;
   logic [17:0] gain;
   logic [26:0] offset;

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;
   logic [8:0] model [8];

   always #(CLK_PERIOD/2) clk = ~clk;

   cfg_serial_port uut (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_load(ser_load),
      .sdata_in(sdata_in), .sdata_out(sdata_out), .sdata_oe(sdata_oe),
      .three_channel(three_channel), .cds_mode(cds_mode), .power_down(power_down),
      .order_rgb(order_rgb), .single_sel(single_sel), .gain(gain), .offset(offset)
   );

   function automatic logic [8:0] exp_mask(input int idx);
      if (idx == 0) return 9'h01C;
      if (idx == 1) return 9'h0F0;
      if (idx <= 4) return 9'h03F;
      return 9'h1FF;
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic run_frame(input bit rw, input logic [2:0] a, input logic [8:0] d, input int nbits,
                            output logic [8:0] rd, output int oe_bad, output int oe_miss);
      logic [15:0] word;
      word = {rw, a, 3'b000, d};
      rd = '0; oe_bad = 0; oe_miss = 0;
      ser_load = 1'b1;
      wait_clk(HALF);
      for (int i = 0; i < nbits; i++) begin
         sdata_in = (i < 16) ? word[15-i] : 1'b0;
         wait_clk(HALF);
         if (i >= 7 && i < 16) begin
            rd[15-i] = sdata_out;
            if (rw && nbits >= 16) begin
               if (!sdata_oe) oe_miss++;
            end else if (sdata_oe) oe_bad++;
         end else if (sdata_oe) oe_bad++;
         ser_clk = 1'b1;
         wait_clk(HALF);
         ser_clk = 1'b0;
      end
      wait_clk(HALF);
      ser_load = 1'b0;
      wait_clk(2*HALF);
      if (sdata_oe) oe_bad++;
   endtask

   task automatic wr(input logic [2:0] a, input logic [8:0] d);
      logic [8:0] r; int b, m;
      run_frame(1'b0, a, d, 16, r, b, m);
      model[a] = d & exp_mask(int'(a));
      check(b == 0, "R9 write frame oe", b, 0);
   endtask

   task automatic rd_check(input logic [2:0] a, input string tag);
      logic [8:0] r; int b, m;
      run_frame(1'b1, a, 9'h0, 16, r, b, m);
      check(r == model[a], tag, r, model[a]);
      check(b == 0 && m == 0, "R9 read frame oe window", b*100 + m, 0);
   endtask

   task automatic t_reset;
      check(three_channel && cds_mode && !power_down, "R3 config defaults",
            {three_channel, cds_mode, power_down}, 3'b110);
      check(order_rgb && single_sel == 3'b100, "R3 mux defaults", {order_rgb, single_sel}, 4'b1100);
      check(gain == 0 && offset == 0, "R3 gain/offset defaults", gain ^ offset, 0);
      check(!sdata_oe, "R9 oe idle", sdata_oe, 0);
   endtask

   task automatic t_config;
      wr(3'd0, 9'h1E3);
      check({three_channel, cds_mode, power_down} == 3'b000, "R4 config fields cleared",
            {three_channel, cds_mode, power_down}, 0);
      rd_check(3'd0, "R4 R1 config readback masked");
      wr(3'd0, 9'h004);
      check({three_channel, cds_mode, power_down} == 3'b001, "R4 power-down set",
            {three_channel, cds_mode, power_down}, 1);
      rd_check(3'd0, "R4 config readback");
   endtask

   task automatic t_mux;
      wr(3'd1, 9'h020);
      check(!order_rgb && single_sel == 3'b010, "R5 green single, reverse order",
            {order_rgb, single_sel}, 4'b0010);
      wr(3'd1, 9'h1FF);
      check(order_rgb && single_sel == 3'b111, "R5 all selects", {order_rgb, single_sel}, 4'b1111);
      rd_check(3'd1, "R5 mux readback masked");
   endtask

   task automatic t_gain;
      wr(3'd2, 9'h1FF);
      wr(3'd3, 9'h015);
      wr(3'd4, 9'h02A);
      check(gain == {6'h2A, 6'h15, 6'h3F}, "R6 gain bus", gain, {6'h2A, 6'h15, 6'h3F});
      rd_check(3'd2, "R6 gain readback upper bits zero");
   endtask

   task automatic t_offset;
      wr(3'd5, 9'h100);
      wr(3'd6, 9'h1FF);
      wr(3'd7, 9'h080);
      check(offset == {9'h080, 9'h1FF, 9'h100}, "R7 offset sign-magnitude bus",
            offset, {9'h080, 9'h1FF, 9'h100});
      rd_check(3'd6, "R7 offset readback");
   endtask

   task automatic t_nondestructive;
      logic [17:0] g0; logic [26:0] o0;
      g0 = gain; o0 = offset;
      rd_check(3'd7, "R8 first read");
      rd_check(3'd7, "R8 repeat read");
      check(gain == g0 && offset == o0, "R8 read leaves state", offset, o0);
   endtask

   task automatic t_length;
      logic [8:0] r; int b, m;
      run_frame(1'b0, 3'd3, 9'h001, 15, r, b, m);
      check(gain[11:6] == 6'h15, "R2 short frame ignored", gain[11:6], 6'h15);
      run_frame(1'b0, 3'd3, 9'h002, 17, r, b, m);
      check(gain[11:6] == 6'h15, "R2 long frame ignored", gain[11:6], 6'h15);
      check(b == 0, "R9 long write frame oe", b, 0);
      rd_check(3'd3, "R2 register intact after bad frames");
   endtask

   task automatic t_addrmap;
      for (int a = 0; a < 8; a++) rd_check(3'(a), "R10 address map readback");
   endtask

   initial begin : watchdog
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
         end
      end
   end

   initial begin : main
      for (int i = 0; i < 8; i++) model[i] = 9'h0;
      model[0] = 9'h018;
      model[1] = 9'h0C0;
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(5);
      t_reset;
      t_config;
      t_mux;
      t_gain;
      t_offset;
      t_nondestructive;
      t_length;
      t_addrmap;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule